// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces the raster control signals that a display transmitter needs at pixel rate: horizontal sync, vertical sync, data enable and a field flag. It counts pixels within a line and lines within a frame, then compares both counts against a set of programmed windows. Both progressive and interlaced rasters are supported.

In interlaced mode the second field is handled in hardware. Its vertical data-enable window is derived from the first field's window, using half the frame height plus a small signed correction code. Its vertical sync edges are placed half a line away from the horizontal sync start, so the two fields interleave correctly.

All timing values reach the block on plain configuration inputs. These values are captured into a shadow copy, so a change made in the middle of a frame never tears the raster. Software therefore computes the windows once per video mode, including a horizontal sync that wraps past the end of the line, and drives them as static levels.

Top module: `vid_raster_gen`

## Requirements
- R1: The pixel counter runs from 0 to `h_max` and then returns to 0. At that return the line counter advances, and it goes back to 0 after `v_max`. The frame is therefore (h_max+1) × (v_max+1) clocks long.
- R2: All four outputs are registered, and each one reflects the counter position of the previous clock.
  - The horizontal data-enable span is [de_h_begin, de_h_end). When begin exceeds end, the span wraps through pixel 0.
  - `de_o` is high only when that span and the vertical span of the current field are both hit. The first field uses [de_v_begin, de_v_end).
- R3: The vertical data-enable span of the second field begins at de_v_begin + floor(v_max/2) + offset.
  - The offset is the 4-bit `odd_ofs` read as two's complement: codes 8 to 15 stand for code − 16.
  - The span is as many lines long as the first field's span.
- R4: Horizontal sync is active over pixels [hs_begin, hs_end) of every line. When hs_begin > hs_end, the window wraps across the line end.
- R5: The first-field vertical sync becomes active at position (vs_even_bline, hs_begin) and inactive at (vs_even_eline, hs_begin). Positions are compared as (line, pixel) pairs in scan order.
- R6: In interlaced mode a second vertical sync pulse runs from (vs_odd_bline, P) to (vs_odd_eline, P). Here P = (hs_begin + floor((h_max+1)/2)) mod (h_max+1), which is half a line from the first pulse's column. In progressive mode this pulse is absent.
- R7: `field_o` is 1 when interlace is selected and the line count is at or above `f1_line`. It is 0 on all other lines and always 0 in progressive mode.
- R8: Each sync polarity bit selects its output's active level: 1 means active high, 0 means active low.
- R9: Configuration changes take effect only for a frame that starts after the clock in which the counters sit at (h_max, v_max), or at any clock while the block is disabled. A change made in mid-frame leaves the current frame unchanged.
- R10: While `en` is low, the counters are held at 0, `de_o` and `field_o` are 0, and both syncs drive their inactive level. After reset, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the raster at its origin |
| interlace | input | 1 | 1 selects a two-field raster |
| hs_pol | input | 1 | Horizontal sync active level |
| vs_pol | input | 1 | Vertical sync active level |
| h_max | input | PW | Last pixel index of a line (total − 1) |
| v_max | input | LW | Last line index of a frame (total − 1) |
| f1_line | input | LW | First line of the second field |
| de_h_begin | input | PW | First pixel of the data-enable span |
| de_h_end | input | PW | Pixel after the data-enable span |
| de_v_begin | input | LW | First active line of the first field |
| de_v_end | input | LW | Line after the first field's active lines |
| odd_ofs | input | 4 | Signed correction for the second field's start line |
| hs_begin | input | PW | Horizontal sync first pixel |
| hs_end | input | PW | Pixel after horizontal sync |
| vs_even_bline | input | LW | First-field vertical sync start line |
| vs_even_eline | input | LW | First-field vertical sync end line |
| vs_odd_bline | input | LW | Second-field vertical sync start line |
| vs_odd_eline | input | LW | Second-field vertical sync end line |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | Field flag |

## Verification
Two events can occur in the same clock: the shadow reload at the last pixel of the last line, and a horizontal sync window that wraps past the line end and is therefore active on both sides of that boundary. The bench reprograms the sync and data-enable windows in mid-frame while a wrapping sync window is in use. It then compares every output on every clock against a behavioural model. That model switches to the new values only after the frame-end pixel, so the old window must persist up to the boundary and the new one must start on the first pixel of the next frame.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
   localparam int unsigned OFS_W   = 4;
   localparam int unsigned FLAG_W  = 3;
   localparam int unsigned MIN_W   = 4;
endpackage

// File: rtl/vrg_hold.sv
module vrg_hold #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   // shadow copy only changes on a load cycle
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/vrg_span.sv
module vrg_span #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] pos,
   input  logic [W-1:0] first,
   input  logic [W-1:0] after,
   output logic         hit
);
   always_comb begin
      if (first <= after) hit = (pos >= first) && (pos < after);
      else                hit = (pos >= first) || (pos < after);
   end
endmodule

// File: rtl/vrg_count.sv
module vrg_count #(
   parameter int unsigned PW = 12,
   parameter int unsigned LW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [PW-1:0] h_max,
   input  logic [LW-1:0] v_max,
   output logic [PW-1:0] pix,
   output logic [LW-1:0] line,
   output logic          frame_end
);
   logic line_end;
   assign line_end  = (pix >= h_max);
   assign frame_end = line_end && (line >= v_max);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix  <= '0;
         line <= '0;
      end else if (!en) begin
         pix  <= '0;
         line <= '0;
      end else if (line_end) begin
         pix  <= '0;
         line <= (line >= v_max) ? '0 : line + 1'b1;
      end else begin
         pix  <= pix + 1'b1;
      end
   end

   assert_pix_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pix < h_max) |=> (pix == $past(pix) + 1'b1));
   assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && frame_end) |=> (pix == '0 && line == '0));
   assert_idle_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pix == '0 && line == '0));
endmodule

// File: rtl/vrg_derive.sv
module vrg_derive #(
   parameter int unsigned PW = 12,
   parameter int unsigned LW = 11
) (
   input  logic [PW-1:0]              h_max,
   input  logic [LW-1:0]              v_max,
   input  logic [LW-1:0]              de_v_begin,
   input  logic [LW-1:0]              de_v_end,
   input  logic [vrg_pkg::OFS_W-1:0]  odd_ofs,
   input  logic [PW-1:0]              hs_begin,
   output logic [LW-1:0]              odd_first,
   output logic [LW-1:0]              odd_after,
   output logic [PW-1:0]              odd_vs_px
);
   localparam int unsigned OW = vrg_pkg::OFS_W;
   logic [LW-1:0] ofs_ext;
   logic [PW:0]   tot, half, sum, wrapped;

   assign ofs_ext   = {{(LW-OW){odd_ofs[OW-1]}}, odd_ofs};
   assign odd_first = de_v_begin + (v_max >> 1) + ofs_ext;
   assign odd_after = odd_first + (de_v_end - de_v_begin);

   assign tot     = {1'b0, h_max} + (PW+1)'(1);
   assign half    = tot >> 1;
   assign sum     = {1'b0, hs_begin} + half;
   assign wrapped = (sum >= tot) ? sum - tot : sum;
   assign odd_vs_px = wrapped[PW-1:0];
endmodule

// File: rtl/vrg_vs_win.sv
module vrg_vs_win #(
   parameter int unsigned PW = 12,
   parameter int unsigned LW = 11
) (
   input  logic          ena,
   input  logic [PW-1:0] pix,
   input  logic [LW-1:0] line,
   input  logic [LW-1:0] bline,
   input  logic [LW-1:0] eline,
   input  logic [PW-1:0] col,
   output logic          hit
);
   logic past_start, past_stop;
   assign past_start = (line > bline) || ((line == bline) && (pix >= col));
   assign past_stop  = (line > eline) || ((line == eline) && (pix >= col));
   assign hit = ena && past_start && !past_stop;
endmodule

// File: rtl/vid_raster_gen.sv
module vid_raster_gen #(
   parameter int unsigned PW = 12,
   parameter int unsigned LW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          interlace,
   input  logic          hs_pol,
   input  logic          vs_pol,
   input  logic [PW-1:0] h_max,
   input  logic [LW-1:0] v_max,
   input  logic [LW-1:0] f1_line,
   input  logic [PW-1:0] de_h_begin,
   input  logic [PW-1:0] de_h_end,
   input  logic [LW-1:0] de_v_begin,
   input  logic [LW-1:0] de_v_end,
   input  logic [3:0]    odd_ofs,
   input  logic [PW-1:0] hs_begin,
   input  logic [PW-1:0] hs_end,
   input  logic [LW-1:0] vs_even_bline,
   input  logic [LW-1:0] vs_even_eline,
   input  logic [LW-1:0] vs_odd_bline,
   input  logic [LW-1:0] vs_odd_eline,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          de_o,
   output logic          field_o
);
   localparam int unsigned CW = vrg_pkg::FLAG_W + vrg_pkg::OFS_W + 5*PW + 8*LW;

   initial begin
      assert (PW >= vrg_pkg::MIN_W) else $error("PW too small");
      assert (LW > vrg_pkg::OFS_W)  else $error("LW too small");
   end

   // ---- shadow configuration ----
   logic          s_il, s_hp, s_vp;
   logic [3:0]    s_ofs;
   logic [PW-1:0] s_hmax, s_dhb, s_dhe, s_hsb, s_hse;
   logic [LW-1:0] s_vmax, s_f1, s_dvb, s_dve, s_veb, s_vee, s_vob, s_voe;
   logic [CW-1:0] cfg_live, cfg_q;
   logic          load, frame_end;

   assign cfg_live = {interlace, hs_pol, vs_pol, odd_ofs,
                      h_max, de_h_begin, de_h_end, hs_begin, hs_end,
                      v_max, f1_line, de_v_begin, de_v_end,
                      vs_even_bline, vs_even_eline, vs_odd_bline, vs_odd_eline};
   assign {s_il, s_hp, s_vp, s_ofs,
           s_hmax, s_dhb, s_dhe, s_hsb, s_hse,
           s_vmax, s_f1, s_dvb, s_dve,
           s_veb, s_vee, s_vob, s_voe} = cfg_q;
   assign load = !en || frame_end;

   vrg_hold #(.W(CW)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(load), .d(cfg_live), .q(cfg_q));

   // ---- counters ----
   logic [PW-1:0] pix;
   logic [LW-1:0] line;

   vrg_count #(.PW(PW), .LW(LW)) u_count (
      .clk(clk), .rst_n(rst_n), .en(en), .h_max(s_hmax), .v_max(s_vmax),
      .pix(pix), .line(line), .frame_end(frame_end));

   // ---- second-field derivation ----
   logic [LW-1:0] odd_first, odd_after;
   logic [PW-1:0] odd_col;

   vrg_derive #(.PW(PW), .LW(LW)) u_derive (
      .h_max(s_hmax), .v_max(s_vmax), .de_v_begin(s_dvb), .de_v_end(s_dve),
      .odd_ofs(s_ofs), .hs_begin(s_hsb),
      .odd_first(odd_first), .odd_after(odd_after), .odd_vs_px(odd_col));

   // ---- windows ----
   logic fld, h_de, v_de_even, v_de_odd, hs_hit;
   assign fld = s_il && (line >= s_f1);

   vrg_span #(.W(PW)) u_hde  (.pos(pix),  .first(s_dhb),     .after(s_dhe),     .hit(h_de));
   vrg_span #(.W(LW)) u_vde0 (.pos(line), .first(s_dvb),     .after(s_dve),     .hit(v_de_even));
   vrg_span #(.W(LW)) u_vde1 (.pos(line), .first(odd_first), .after(odd_after), .hit(v_de_odd));
   vrg_span #(.W(PW)) u_hs   (.pos(pix),  .first(s_hsb),     .after(s_hse),     .hit(hs_hit));

   logic [1:0]    vs_hit;
   logic [LW-1:0] vs_b [2];
   logic [LW-1:0] vs_e [2];
   logic [PW-1:0] vs_c [2];
   logic          vs_ena [2];
   assign vs_b[0] = s_veb;  assign vs_e[0] = s_vee;  assign vs_c[0] = s_hsb;  assign vs_ena[0] = 1'b1;
   assign vs_b[1] = s_vob;  assign vs_e[1] = s_voe;  assign vs_c[1] = odd_col; assign vs_ena[1] = s_il;

   for (genvar g = 0; g < 2; g++) begin : g_vs
      vrg_vs_win #(.PW(PW), .LW(LW)) u_win (
         .ena(vs_ena[g]), .pix(pix), .line(line),
         .bline(vs_b[g]), .eline(vs_e[g]), .col(vs_c[g]), .hit(vs_hit[g]));
   end

   // ---- output stage ----
   logic de_next;
   assign de_next = h_de && (fld ? v_de_odd : v_de_even);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync_o <= 1'b0;
         vsync_o <= 1'b0;
         de_o    <= 1'b0;
         field_o <= 1'b0;
      end else if (!en) begin
         hsync_o <= ~s_hp;
         vsync_o <= ~s_vp;
         de_o    <= 1'b0;
         field_o <= 1'b0;
      end else begin
         hsync_o <= hs_hit ? s_hp : ~s_hp;
         vsync_o <= (|vs_hit) ? s_vp : ~s_vp;
         de_o    <= de_next;
         field_o <= fld;
      end
   end

   assert_idle_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!de_o && !field_o && hsync_o != $past(s_hp) && vsync_o != $past(s_vp)));
   assert_field_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !s_il) |=> !field_o);
   assert_no_odd_vs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !s_il |-> !vs_hit[1]);
endmodule

// File: tb/vid_raster_gen_tb_top.sv
module vid_raster_gen_tb_top;
   localparam int PW = 12;
   localparam int LW = 11;
   localparam int LMASK = (1 << LW) - 1;

   logic clk = 0, rst_n = 0, en = 0, interlace = 0, hs_pol = 1, vs_pol = 1;
   logic [PW-1:0] h_max = 19, de_h_begin = 4, de_h_end = 16, hs_begin = 17, hs_end = 2;
   logic [LW-1:0] v_max = 9, f1_line = 5, de_v_begin = 2, de_v_end = 8;
   logic [LW-1:0] vs_even_bline = 0, vs_even_eline = 1, vs_odd_bline = 5, vs_odd_eline = 6;
   logic [3:0]    odd_ofs = 0;
   logic hsync_o, vsync_o, de_o, field_o;

   always #10 clk = ~clk;

   vid_raster_gen #(.PW(PW), .LW(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .interlace(interlace),
      .hs_pol(hs_pol), .vs_pol(vs_pol), .h_max(h_max), .v_max(v_max),
      .f1_line(f1_line), .de_h_begin(de_h_begin), .de_h_end(de_h_end),
      .de_v_begin(de_v_begin), .de_v_end(de_v_end), .odd_ofs(odd_ofs),
      .hs_begin(hs_begin), .hs_end(hs_end),
      .vs_even_bline(vs_even_bline), .vs_even_eline(vs_even_eline),
      .vs_odd_bline(vs_odd_bline), .vs_odd_eline(vs_odd_eline),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .field_o(field_o));

   int errors = 0, checks = 0;
   bit done = 0;
   string ph = "R1";

   // ---- behavioural reference ----
   int m_pix = 0, m_line = 0;
   int s_il, s_hp, s_vp, s_ofs, s_hmax, s_dhb, s_dhe, s_hsb, s_hse;
   int s_vmax, s_f1, s_dvb, s_dve, s_veb, s_vee, s_vob, s_voe;
   bit e_hs = 0, e_vs = 0, e_de = 0, e_fld = 0;

   function automatic bit in_span(int p, int b, int e);
      return (b <= e) ? (p >= b && p < e) : (p >= b || p < e);
   endfunction
   function automatic bit at_or_after(int l, int p, int bl, int bp);
      return (l > bl) || (l == bl && p >= bp);
   endfunction

   task automatic grab();
      s_il = interlace; s_hp = hs_pol; s_vp = vs_pol; s_ofs = odd_ofs;
      s_hmax = h_max; s_dhb = de_h_begin; s_dhe = de_h_end; s_hsb = hs_begin; s_hse = hs_end;
      s_vmax = v_max; s_f1 = f1_line; s_dvb = de_v_begin; s_dve = de_v_end;
      s_veb = vs_even_bline; s_vee = vs_even_eline; s_vob = vs_odd_bline; s_voe = vs_odd_eline;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pix = 0; m_line = 0;
         {s_il, s_hp, s_vp, s_ofs, s_hmax, s_dhb, s_dhe, s_hsb, s_hse} = '0;
         {s_vmax, s_f1, s_dvb, s_dve, s_veb, s_vee, s_vob, s_voe} = '0;
         e_hs = 0; e_vs = 0; e_de = 0; e_fld = 0;
      end else begin
         bit fld, ld;
         int ofs, ob, oe, tot, col;
         fld = (s_il != 0) && (m_line >= s_f1);
         ofs = (s_ofs > 7) ? s_ofs - 16 : s_ofs;                 // R3 signed code
         ob  = (s_dvb + s_vmax / 2 + ofs) & LMASK;
         oe  = (ob + ((s_dve - s_dvb) & LMASK)) & LMASK;
         tot = s_hmax + 1;
         col = (s_hsb + tot / 2) % tot;                           // R6 half line
         if (!en) begin
            e_hs = !s_hp; e_vs = !s_vp; e_de = 0; e_fld = 0;
         end else begin
            bit hs_a, vs_a;
            hs_a = in_span(m_pix, s_hsb, s_hse);
            vs_a = (at_or_after(m_line, m_pix, s_veb, s_hsb) && !at_or_after(m_line, m_pix, s_vee, s_hsb)) ||
                   (s_il != 0 && at_or_after(m_line, m_pix, s_vob, col) && !at_or_after(m_line, m_pix, s_voe, col));
            e_hs  = hs_a ? s_hp[0] : !s_hp[0];
            e_vs  = vs_a ? s_vp[0] : !s_vp[0];
            e_de  = in_span(m_pix, s_dhb, s_dhe) &&
                    (fld ? in_span(m_line, ob, oe) : in_span(m_line, s_dvb, s_dve));
            e_fld = fld;
         end
         ld = !en || (m_pix >= s_hmax && m_line >= s_vmax);
         if (!en) begin
            m_pix = 0; m_line = 0;
         end else if (m_pix >= s_hmax) begin
            m_pix = 0;
            m_line = (m_line >= s_vmax) ? 0 : m_line + 1;
         end else m_pix++;
         if (ld) grab();
      end
   end

   task automatic chk(string req, string what, logic got, bit exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s [%s] %s got %0b expected %0b at %0t", req, ph, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n && !done) begin
      chk("R1 R4 R8", "hsync", hsync_o, e_hs);
      chk("R5 R6", "vsync", vsync_o, e_vs);
      chk("R2 R3", "de", de_o, e_de);
      chk("R7", "field", field_o, e_fld);
   end

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      run(3);
      chk("R10", "reset hsync", hsync_o, 0);
      chk("R10", "reset vsync", vsync_o, 0);
      chk("R10", "reset de", de_o, 0);
      chk("R10", "reset field", field_o, 0);
      rst_n = 1;
      run(2);
      // progressive raster, hsync window wrapping past line end (R4)
      ph = "R1"; en = 1;
      run(450);
      // mid-frame reprogramming; old window must last until frame end (R9)
      ph = "R9";
      run(37);
      hs_begin = 15; hs_end = 18; de_h_begin = 3; de_h_end = 15;
      run(260);
      // interlaced, negative offset code 15 = -1 (R3, R6, R7)
      ph = "R3";
      interlace = 1; v_max = 10; f1_line = 5; de_v_begin = 1; de_v_end = 4;
      odd_ofs = 4'd15; hs_begin = 17; hs_end = 2; hs_pol = 0; vs_pol = 0;
      run(520);
      // positive offset code
      odd_ofs = 4'd3;
      run(480);
      // disabled mid-frame, polarity change while idle (R10, R8)
      ph = "R10";
      run(53);
      en = 0;
      run(10);
      hs_pol = 1;
      run(20);
      en = 1;
      ph = "R8";
      run(300);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule